// File: doc/BRIEF.md
# VBUS Level Status Tracker

This block keeps the one-bit VBUS presence status of a USB controller. Two external comparators report the bus voltage as digital levels. The lower one is active when VBUS is at or above roughly 1.4 V, which marks a valid session. The upper one is active when VBUS is at or above roughly 4.4 V, which marks a valid supply. Both levels are resynchronised into the controller clock domain. The status bit then follows them with hysteresis: it sets on the upper threshold and clears only when the lower threshold is lost.

Every change of the status bit, in either direction, sets a sticky change flag. Software clears that flag with a one-cycle strobe. The flag, gated by an enable, forms the interrupt output. A separate attach-permit output follows the status bit, so the peripheral side of the controller cannot connect to the bus while the status is clear.

Top module: `vbus_level_tracker`

## Requirements
- R1: While reset is asserted, the status, change flag, interrupt and attach-permit outputs are all 0.
- R2: Each comparator input passes through SYNC_STAGES flops (default 2) before use. With the default, a change on an input shows on the status output at the third rising clock edge after it is driven, and not at the second.
- R3: The status output sets when the synchronised upper-threshold (vbus-valid) input is 1.
- R4: Once set, the status stays 1 while the synchronised session-valid input is 1, even after the vbus-valid input drops. With only the session-valid input at 1, a clear status stays clear.
- R5: The status clears when the session-valid input is 0 and the vbus-valid input is 0. If the vbus-valid input is 1, the status is set whatever the session-valid input is.
- R6: The change flag sets at the same clock edge at which the status output changes, on rising and on falling transitions alike.
- R7: The change flag stays 1 until a clear strobe is sampled. The strobe clears it at the next rising edge.
- R8: If a status change and a clear strobe fall on the same edge, the change flag stays 1.
- R9: The interrupt output equals the change flag ANDed with the interrupt-enable input, with no register in between.
- R10: The attach-permit output is 1 only while the status output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sess_vld_i | input | 1 | Lower comparator level (session valid) |
| vbus_vld_i | input | 1 | Upper comparator level (vbus valid) |
| flag_clr_i | input | 1 | One-cycle strobe that clears the change flag |
| irq_en_i | input | 1 | Interrupt enable |
| vbus_ok_o | output | 1 | VBUS status bit |
| chg_flag_o | output | 1 | Sticky status-change flag |
| irq_o | output | 1 | Interrupt request |
| attach_ok_o | output | 1 | Peripheral attach permitted |

## Verification
The bound checker checks the following on every cycle:
- any change of the status output is matched by a set change flag;
- the flag is sticky while no clear strobe is present;
- a clear strobe takes effect unless a new edge arrives with it;
- the interrupt and attach-permit outputs never assert without their sources.

The hysteresis itself and the exact synchroniser latency depend on the input history. Only the bench scenarios show them, by walking the input levels through set, hold, release and set-while-session-low sequences and sampling the outputs at the predicted edge.

// File: rtl/vbt_pkg.sv
package vbt_pkg;

   typedef struct packed {
      logic vbus;   // upper threshold level
      logic sess;   // lower threshold level
   } vbt_lvl_t;

   localparam int LVL_W = $bits(vbt_lvl_t);

   // Hysteresis rule: upper threshold sets, loss of lower threshold clears.
   function automatic logic vbt_next_status(input vbt_lvl_t lvl, input logic cur);
      if (lvl.vbus)
         return 1'b1;
      else if (!lvl.sess)
         return 1'b0;
      else
         return cur;
   endfunction

endpackage

// File: rtl/vbt_sync.sv
module vbt_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("vbt_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("vbt_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_i;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[LAST];

endmodule

// File: rtl/vbt_hyst.sv
module vbt_hyst
   import vbt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  vbt_lvl_t lvl_i,
   output logic     status_o,
   output logic     change_o
);

   logic status_q;
   logic status_d;

   always_comb begin
      status_d = vbt_next_status(lvl_i, status_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= 1'b0;
      else        status_q <= status_d;
   end

   assign status_o = status_q;
   assign change_o = status_d ^ status_q;

endmodule

// File: rtl/vbt_event_flag.sv
module vbt_event_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;
   logic flag_d;

   if (SET_WINS) begin : g_set_priority
      always_comb flag_d = set_i | (flag_q & ~clr_i);
   end else begin : g_clr_priority
      always_comb flag_d = ~clr_i & (set_i | flag_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/vbus_level_tracker.sv
module vbus_level_tracker
   import vbt_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sess_vld_i,
   input  logic vbus_vld_i,
   input  logic flag_clr_i,
   input  logic irq_en_i,
   output logic vbus_ok_o,
   output logic chg_flag_o,
   output logic irq_o,
   output logic attach_ok_o
);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("vbus_level_tracker: SYNC_STAGES must be at least 2");
   end

   vbt_lvl_t lvl_raw;
   vbt_lvl_t lvl_sync;
   logic     status;
   logic     status_chg;
   logic     flag;

   assign lvl_raw.vbus = vbus_vld_i;
   assign lvl_raw.sess = sess_vld_i;

   vbt_sync #(
      .WIDTH  (LVL_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (lvl_raw),
      .q_o   (lvl_sync)
   );

   vbt_hyst u_hyst (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_i    (lvl_sync),
      .status_o (status),
      .change_o (status_chg)
   );

   vbt_event_flag #(
      .SET_WINS (1'b1)
   ) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (status_chg),
      .clr_i  (flag_clr_i),
      .flag_o (flag)
   );

   assign vbus_ok_o   = status;
   assign chg_flag_o  = flag;
   assign irq_o       = flag & irq_en_i;
   assign attach_ok_o = status;

endmodule

// File: rtl/vbt_checker.sv
module vbt_checker (
   input logic clk,
   input logic rst_n,
   input logic flag_clr_i,
   input logic irq_en_i,
   input logic vbus_ok_o,
   input logic chg_flag_o,
   input logic irq_o,
   input logic attach_ok_o
);

   // R1: outputs quiet in reset
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (!vbus_ok_o && !chg_flag_o && !irq_o && !attach_ok_o);
      end
   end

   a_r6_flag_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (vbus_ok_o != $past(vbus_ok_o)) |-> chg_flag_o);

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_flag_o && !flag_clr_i) |=> chg_flag_o);

   a_r8_clear_unless_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_flag_o && flag_clr_i) |=> (!chg_flag_o || (vbus_ok_o != $past(vbus_ok_o))));

   a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (irq_en_i && chg_flag_o));

   a_r10_attach_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      !vbus_ok_o |-> !attach_ok_o);

endmodule

bind vbus_level_tracker vbt_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flag_clr_i  (flag_clr_i),
   .irq_en_i    (irq_en_i),
   .vbus_ok_o   (vbus_ok_o),
   .chg_flag_o  (chg_flag_o),
   .irq_o       (irq_o),
   .attach_ok_o (attach_ok_o)
);

// File: tb/sim_vbus_level_tracker.sv
`timescale 1ns/1ps
module sim_vbus_level_tracker;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sess_vld_i = 1'b0;
   logic vbus_vld_i = 1'b0;
   logic flag_clr_i = 1'b0;
   logic irq_en_i = 1'b0;
   logic vbus_ok_o, chg_flag_o, irq_o, attach_ok_o;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int    at;
      logic  st;
      logic  fl;
      logic  irq;
      logic  att;
      string tag;
   } exp_t;

   exp_t sb[$];

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk) cyc <= cyc + 1;

   vbus_level_tracker u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .sess_vld_i  (sess_vld_i),
      .vbus_vld_i  (vbus_vld_i),
      .flag_clr_i  (flag_clr_i),
      .irq_en_i    (irq_en_i),
      .vbus_ok_o   (vbus_ok_o),
      .chg_flag_o  (chg_flag_o),
      .irq_o       (irq_o),
      .attach_ok_o (attach_ok_o)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_in(input int dly, input logic st, input logic fl,
                            input logic irq, input logic att, input string tag);
      exp_t e;
      e.at = cyc + dly; e.st = st; e.fl = fl; e.irq = irq; e.att = att; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compare results as they appear
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].at <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (e.at != cyc || vbus_ok_o !== e.st || chg_flag_o !== e.fl ||
             irq_o !== e.irq || attach_ok_o !== e.att) begin
            errors++;
            $display("FAIL %s cyc %0d: got st=%b fl=%b irq=%b att=%b, expected st=%b fl=%b irq=%b att=%b (due %0d)",
                     e.tag, cyc, vbus_ok_o, chg_flag_o, irq_o, attach_ok_o,
                     e.st, e.fl, e.irq, e.att, e.at);
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      expect_in(0, 0, 0, 0, 0, "R1 reset");
      tick();
      rst_n = 1'b1;
      tick();

      // R4: session only, clear status stays clear
      sess_vld_i = 1'b1;
      expect_in(3, 0, 0, 0, 0, "R4 session only");
      repeat (4) tick();

      // R2/R3/R6/R10: upper threshold sets status
      vbus_vld_i = 1'b1;
      expect_in(2, 0, 0, 0, 0, "R2 not before sync");
      expect_in(3, 1, 1, 0, 1, "R3 R6 R10 set");
      repeat (4) tick();

      // R9: enable gates flag combinationally
      irq_en_i = 1'b1;
      expect_in(0, 1, 1, 1, 1, "R9 enable");
      tick();

      // R7: clear strobe
      flag_clr_i = 1'b1;
      expect_in(1, 1, 0, 0, 1, "R7 clear");
      tick();
      flag_clr_i = 1'b0;
      tick();

      // R4: hysteresis hold
      vbus_vld_i = 1'b0;
      expect_in(3, 1, 0, 0, 1, "R4 hold");
      repeat (4) tick();

      // R5/R6: session lost clears status
      sess_vld_i = 1'b0;
      expect_in(3, 0, 1, 1, 0, "R5 R6 fall");
      expect_in(4, 0, 1, 1, 0, "R7 sticky");
      repeat (5) tick();

      flag_clr_i = 1'b1;
      expect_in(1, 0, 0, 0, 0, "R7 clear2");
      tick();
      flag_clr_i = 1'b0;
      tick();

      // R5 set wins with session low; R8 clear coincides with edge
      vbus_vld_i = 1'b1;
      expect_in(3, 1, 1, 1, 1, "R5 R8 set with clear");
      expect_in(4, 1, 1, 1, 1, "R8 still set");
      tick(); tick();
      flag_clr_i = 1'b1;
      tick();
      flag_clr_i = 1'b0;
      tick(); tick();

      // R9: disable
      irq_en_i = 1'b0;
      expect_in(0, 1, 1, 0, 1, "R9 disable");
      repeat (3) tick();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule